// File: doc/BRIEF.md
# Convolution Lane Multiply-Accumulate Array

This block is the arithmetic core of a vector convolution engine. It holds a row of identical lanes. Each lane takes one unsigned 8-bit pixel, multiplies it by a signed 16-bit weight, and adds the product to a signed 32-bit partial sum. The result is a new 32-bit partial sum for one output of a shared output feature map. A caller either supplies one weight per lane, or has the weight held in lane 0 of the weight input shared by every lane. Sharing one weight across all lanes lets a single filter tap be applied to many neighbouring windows at once.

The same lanes also evaluate a piecewise-linear activation. The caller looks up per-lane slope and offset coefficients elsewhere. In activation mode it presents the slope on the weight input, the offset on the accumulator input and the interpolation fraction on the pixel input. Coefficients are always taken per lane in this mode. The unit is fully pipelined with a fixed two-cycle latency and accepts one operation per clock. A valid flag travels alongside the data.

Top module: `lmac_array`

## Requirements
- R1: For an accepted operation, lane i returns acc + pix * w, taken modulo 2^32. Here pix is bits [8i+7:8i] of `pix_in` read as unsigned, w is a 16-bit two's complement weight and acc is bits [32i+31:32i] of `acc_in`. The result appears on bits [32i+31:32i] of `res_out`.
- R2: All 32 lanes compute independently in the same operation, and the value in one lane has no effect on any other lane.
- R3: When `bcast` is 1 and `act_mode` is 0, every lane uses bits [15:0] of `wgt_in` (lane 0) as its weight.
- R4: When `act_mode` is 1, lane i uses its own weight field bits [16i+15:16i] as the slope and its accumulator field as the offset, and `bcast` has no effect.
- R5: A result is due exactly two clock edges after the edge that accepts the operation, and a new operation can be accepted on every edge.
- R6: `out_valid` equals `in_valid` delayed by two clock edges.
- R7: While no result completes, `res_out` keeps the last result, whatever is on the data inputs when `in_valid` is 0.
- R8: While `rst_n` is low, `out_valid` is 0 and `res_out` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| bcast | input | 1 | Share the lane 0 weight across all lanes (convolution mode only) |
| act_mode | input | 1 | 1: activation (slope/offset), 0: convolution |
| pix_in | input | 256 | 32 unsigned 8-bit pixels or interpolation fractions |
| wgt_in | input | 512 | 32 signed 16-bit weights or slopes |
| acc_in | input | 1024 | 32 signed 32-bit partial sums or offsets |
| out_valid | output | 1 | Result on `res_out` completed this cycle |
| res_out | output | 1024 | 32 signed 32-bit results |

## Verification
Every operation is issued with the cycle number at which it is driven. Its result and `out_valid` are due two edges later, so the monitor samples shortly after each rising edge and requires the popped item's due cycle to equal the current cycle. This catches a result that arrives early, late or without its valid flag. On cycles with no valid output, the monitor compares `res_out` against the last result seen while idle cycles drive random data. This shows that the data inputs have no effect while `in_valid` is low.

// File: rtl/lmac_pkg.sv
package lmac_pkg;

    localparam int LMAC_LANES = 32;
    localparam int LMAC_PIX_W = 8;
    localparam int LMAC_WGT_W = 16;
    localparam int LMAC_ACC_W = 32;

    typedef enum logic {
        OP_CONV = 1'b0,
        OP_ACT  = 1'b1
    } lmac_op_e;

endpackage

// File: rtl/lmac_wsel.sv
module lmac_wsel
    import lmac_pkg::*;
#(
    parameter int LANES = LMAC_LANES,
    parameter int WGT_W = LMAC_WGT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   bcast,
    input  lmac_op_e               op,
    input  logic [LANES*WGT_W-1:0] wgt_in,
    output logic [LANES*WGT_W-1:0] wgt_sel
);

    logic share;

    always_comb begin
        share = bcast && (op == OP_CONV);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            wgt_sel[g*WGT_W +: WGT_W] = share ? wgt_in[WGT_W-1:0]
                                              : wgt_in[g*WGT_W +: WGT_W];
        end

        // R3: in convolution mode with sharing, each lane sees lane 0's weight
        a_r3_bcast_lane0 : assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && bcast && op == OP_CONV)
                |-> wgt_sel[g*WGT_W +: WGT_W] == wgt_in[WGT_W-1:0]);

        // R4: in activation mode each lane keeps its own slope
        a_r4_act_per_lane : assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == OP_ACT)
                |-> wgt_sel[g*WGT_W +: WGT_W] == wgt_in[g*WGT_W +: WGT_W]);
    end

endmodule

// File: rtl/lmac_lane.sv
module lmac_lane
    import lmac_pkg::*;
#(
    parameter int PIX_W = LMAC_PIX_W,
    parameter int WGT_W = LMAC_WGT_W,
    parameter int ACC_W = LMAC_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_mul,
    input  logic             en_add,
    input  logic [PIX_W-1:0] pix,
    input  logic [WGT_W-1:0] wgt,
    input  logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] res
);

    localparam int PROD_W = PIX_W + WGT_W + 1;
    localparam int EXT_W  = ACC_W - PROD_W;

    typedef struct packed {
        logic signed [PROD_W-1:0] prod;
        logic [ACC_W-1:0]         addend;
        logic [ACC_W-1:0]         res;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_mul) begin
            st_d.prod   = $signed({1'b0, pix}) * $signed(wgt);
            st_d.addend = acc;
        end
        if (en_add) begin
            st_d.res = st_q.addend + {{EXT_W{st_q.prod[PROD_W-1]}}, st_q.prod};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res = st_q.res;

    // R1: a zero pixel yields a zero product in the first stage
    a_r1_zero_pixel : assert property (@(posedge clk) disable iff (!rst_n)
        (en_mul && pix == '0) |=> st_q.prod == '0);

    // R1: a zero weight yields a zero product in the first stage
    a_r1_zero_weight : assert property (@(posedge clk) disable iff (!rst_n)
        (en_mul && wgt == '0) |=> st_q.prod == '0);

endmodule

// File: rtl/lmac_array.sv
module lmac_array
    import lmac_pkg::*;
#(
    parameter int LANES = LMAC_LANES,
    parameter int PIX_W = LMAC_PIX_W,
    parameter int WGT_W = LMAC_WGT_W,
    parameter int ACC_W = LMAC_ACC_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   bcast,
    input  logic                   act_mode,
    input  logic [LANES*PIX_W-1:0] pix_in,
    input  logic [LANES*WGT_W-1:0] wgt_in,
    input  logic [LANES*ACC_W-1:0] acc_in,
    output logic                   out_valid,
    output logic [LANES*ACC_W-1:0] res_out
);

    typedef struct packed {
        logic v_mul;
        logic v_add;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    lmac_op_e op;
    logic [LANES*WGT_W-1:0] wgt_sel;

    always_comb begin
        op = act_mode ? OP_ACT : OP_CONV;
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.v_mul = in_valid;
        ctl_d.v_add = ctl_q.v_mul;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign out_valid = ctl_q.v_add;

    lmac_wsel #(
        .LANES (LANES),
        .WGT_W (WGT_W)
    ) i_wsel (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .bcast    (bcast),
        .op       (op),
        .wgt_in   (wgt_in),
        .wgt_sel  (wgt_sel)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lmac_lane #(
            .PIX_W (PIX_W),
            .WGT_W (WGT_W),
            .ACC_W (ACC_W)
        ) i_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_mul (in_valid),
            .en_add (ctl_q.v_mul),
            .pix    (pix_in[g*PIX_W +: PIX_W]),
            .wgt    (wgt_sel[g*WGT_W +: WGT_W]),
            .acc    (acc_in[g*ACC_W +: ACC_W]),
            .res    (res_out[g*ACC_W +: ACC_W])
        );
    end

    // R6: valid travels through both stages
    a_r6_valid_stage1 : assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ctl_q.v_mul);
    a_r6_valid_stage2 : assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.v_mul |=> out_valid);
    a_r6_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.v_mul |=> !out_valid);

    // R7: results hold when nothing completes
    a_r7_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.v_mul |=> $stable(res_out));

endmodule

// File: tb/test_lmac_array.sv
module test_lmac_array;

    localparam int NL = 32;

    typedef struct {
        logic [NL*32-1:0] res;
        int               due;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             bcast = 1'b0;
    logic             act_mode = 1'b0;
    logic [NL*8-1:0]  pix_in = '0;
    logic [NL*16-1:0] wgt_in = '0;
    logic [NL*32-1:0] acc_in = '0;
    logic             out_valid;
    logic [NL*32-1:0] res_out;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];
    logic [NL*32-1:0] last_res = '0;
    logic             seen = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    lmac_array i_lmac_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .bcast     (bcast),
        .act_mode  (act_mode),
        .pix_in    (pix_in),
        .wgt_in    (wgt_in),
        .acc_in    (acc_in),
        .out_valid (out_valid),
        .res_out   (res_out)
    );

    function automatic logic [NL*32-1:0] model(input logic b, input logic a,
                                               input logic [NL*8-1:0] p,
                                               input logic [NL*16-1:0] w,
                                               input logic [NL*32-1:0] c);
        logic [NL*32-1:0] r;
        for (int i = 0; i < NL; i++) begin
            logic signed [15:0] wl;
            int                 pv;
            wl = (b && !a) ? w[15:0] : w[16*i +: 16];
            pv = int'(p[8*i +: 8]);
            r[32*i +: 32] = c[32*i +: 32] + 32'(pv * int'(wl));
        end
        return r;
    endfunction

    task automatic issue(input logic b, input logic a, input logic [NL*8-1:0] p,
                         input logic [NL*16-1:0] w, input logic [NL*32-1:0] c,
                         input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        bcast    = b;
        act_mode = a;
        pix_in   = p;
        wgt_in   = w;
        acc_in   = c;
        e.res = model(b, a, p, w, c);
        e.due = cyc + 2;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            bcast    = 1'($urandom);
            act_mode = 1'($urandom);
            for (int i = 0; i < NL; i++) begin
                pix_in[8*i +: 8]   = 8'($urandom);
                wgt_in[16*i +: 16] = 16'($urandom);
                acc_in[32*i +: 32] = $urandom;
            end
        end
    endtask

    task automatic rnd(output logic [NL*8-1:0] p, output logic [NL*16-1:0] w,
                       output logic [NL*32-1:0] c);
        for (int i = 0; i < NL; i++) begin
            p[8*i +: 8]   = 8'($urandom);
            w[16*i +: 16] = 16'($urandom);
            c[32*i +: 32] = $urandom;
        end
    endtask

    // monitor: compares each completed result with the scoreboard head
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (rst_n) begin
                if (out_valid) begin
                    checks++;
                    if (sb.size() == 0) begin
                        errors++;
                        $display("FAIL R6: out_valid=1 at cycle %0d, expected 0 (nothing pending)", cyc);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        if (e.due != cyc) begin
                            errors++;
                            $display("FAIL R5 (%s): result at cycle %0d, expected cycle %0d", e.tag, cyc, e.due);
                        end else if (res_out !== e.res) begin
                            errors++;
                            for (int i = 0; i < NL; i++) begin
                                if (res_out[32*i +: 32] !== e.res[32*i +: 32]) begin
                                    $display("FAIL %s lane %0d: got %h expected %h", e.tag, i,
                                             res_out[32*i +: 32], e.res[32*i +: 32]);
                                    break;
                                end
                            end
                        end
                    end
                    last_res = res_out;
                    seen = 1'b1;
                end else begin
                    if (sb.size() != 0 && sb[0].due == cyc) begin
                        checks++;
                        errors++;
                        $display("FAIL R6 (%s): out_valid=0 at cycle %0d, expected 1", sb[0].tag, cyc);
                        void'(sb.pop_front());
                    end
                    if (seen) begin
                        checks++;
                        if (res_out !== last_res) begin
                            errors++;
                            $display("FAIL R7: res_out changed while idle, got %h expected %h",
                                     res_out[31:0], last_res[31:0]);
                        end
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NL*8-1:0]  p;
        logic [NL*16-1:0] w;
        logic [NL*32-1:0] c;

        repeat (3) @(negedge clk);
        // R8: reset state
        checks++;
        if (out_valid !== 1'b0 || res_out !== '0) begin
            errors++;
            $display("FAIL R8: out_valid=%b res_out[31:0]=%h expected 0 and 0", out_valid, res_out[31:0]);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1: all zero pixels return the accumulator
        rnd(p, w, c);
        issue(1'b0, 1'b0, '0, w, c, "R1 zero pixel");
        // R1: extremes: max pixel times most negative weight plus zero
        issue(1'b0, 1'b0, {NL{8'hFF}}, {NL{16'h8000}}, '0, "R1 extreme negative");
        // R1: wrap past the top of the 32-bit range
        issue(1'b0, 1'b0, {NL{8'hFF}}, {NL{16'h7FFF}}, {NL{32'h7FFF_FFFF}}, "R1 wrap");
        idle(3);

        // R2: lanes differ from each other; R5 back-to-back stream
        for (int k = 0; k < 8; k++) begin
            rnd(p, w, c);
            issue(1'b0, 1'b0, p, w, c, "R2 R5 per-lane stream");
        end
        idle(1);

        // R3: shared weight from lane 0
        for (int k = 0; k < 4; k++) begin
            rnd(p, w, c);
            issue(1'b1, 1'b0, p, w, c, "R3 broadcast weight");
        end
        // R4: activation, bcast set but ignored
        for (int k = 0; k < 4; k++) begin
            rnd(p, w, c);
            issue(1'b1, 1'b1, p, w, c, "R4 activation bcast ignored");
        end
        rnd(p, w, c);
        issue(1'b0, 1'b1, p, w, c, "R4 activation");

        // R6: gapped traffic
        for (int k = 0; k < 6; k++) begin
            rnd(p, w, c);
            issue(1'($urandom), 1'($urandom), p, w, c, "R6 gapped");
            idle(k % 3);
        end

        // R7: long idle with random data
        idle(8);
        wait (sb.size() == 0);
        idle(4);

        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R6: out_valid=%b after drain, expected 0", out_valid);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule